// File: doc/BRIEF.md
# Video Sync Output Conditioning Unit

This block sits between a video timing generator and the sync output pins. It runs on the output pixel clock. It takes the internally generated horizontal and vertical sync pulses, both active-high, and produces the two registered sync outputs.

On the vertical path the block can push the whole vertical pulse later by 0 to 255 pixel clocks. This adjusts the phase between the vertical and horizontal sync edges. The horizontal pin carries either plain horizontal sync or a composite sync. Composite sync is inverted during the vertical interval (serration). It can optionally carry half-line equalization pulses for a fixed number of lines on each side of the vertical interval. Each pin has its own polarity control.

All settings are decoded levels. The block captures them at the start of each frame, which is the rising edge of the incoming vertical sync. A change made in the middle of a frame therefore never produces a partial pulse.

Top module: `sync_out_cond`

## Requirements
- R1: Each output has its own invert bit (`cfg_vs_inv`, `cfg_hs_inv`). When the bit is 0 the output is active-high. When it is 1 the output is the exact complement of the non-inverted output.
- R2: `cfg_csync_sel` = 0 puts plain horizontal sync on `hs_out`. `cfg_csync_sel` = 1 puts composite sync on `hs_out`.
- R3: With composite sync off, `vs_out` follows `vs_in` delayed by `cfg_vdelay` extra clocks (0 to 255). For example, code 8'h80 gives 128 clocks. Both the rising and the falling edge move, so the pulse width is unchanged. This requires a vertical pulse longer than 255 clocks.
- R4: While composite sync is selected, the effective vertical delay is 0, whatever `cfg_vdelay` holds.
- R5: With composite sync and `cfg_no_eq` = 1, composite sync equals horizontal sync at every pixel outside the vertical interval, and no equalization pulses appear.
- R6: With composite sync and `cfg_no_eq` = 0, equalization pulses are output in two places:
  - the EQ_LINES lines that follow the vertical pulse;
  - the last EQ_LINES lines of a frame, but only once a full previous frame length is known, that is, from the second frame after reset.

  In those lines, let p be the pixel offset from the horizontal rising edge, w be `cfg_hs_width`/2 (rounded down) and h be `cfg_half_line`. Composite sync is high exactly when p < w, or when h <= p < h + w.
- R7: With composite sync selected and `vs_in` high, composite sync is the inverse of `hs_in`.
- R8: The settings are sampled only in the cycle in which `vs_in` rises, and that cycle already uses them. A change at any other time has no effect until the next frame.
- R9: Each output lags its input by exactly one clock when the delay is 0, and nothing passes through combinationally.
- R10: While `rst` is high at a clock edge, both outputs go low. Reset also restores plain, non-inverted, undelayed behaviour until the first frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hs_in | input | 1 | Internal horizontal sync, active-high |
| vs_in | input | 1 | Internal vertical sync, active-high; its rising edge marks a frame start |
| cfg_vs_inv | input | 1 | 1 makes `vs_out` active-low |
| cfg_hs_inv | input | 1 | 1 makes `hs_out` active-low |
| cfg_csync_sel | input | 1 | 0: plain horizontal sync on `hs_out`; 1: composite sync |
| cfg_no_eq | input | 1 | 1 removes the equalization pulses from composite sync |
| cfg_vdelay | input | 8 | Vertical sync delay in pixel clocks |
| cfg_half_line | input | PIX_W | Half-line period in pixel clocks |
| cfg_hs_width | input | PIX_W | Horizontal sync width in pixel clocks |
| hs_out | output | 1 | Registered horizontal or composite sync output |
| vs_out | output | 1 | Registered vertical sync output |

## Verification
The bench compares every output cycle with its own model over a range of frames. These frames exercise the following corner cases:
- Delays of 1, 2, 128 and 255. A counter that is off by one, or that moves only one edge, would shift the pulse or change its width.
- A large delay code while composite sync is on. A design that fails to force the delay to 0 would misplace the vertical pulse.
- The first frame after reset, which must have no pre-equalization. A design that predicts a frame length it has not yet measured would emit stray pulses at the end of that frame.
- Settings changed in the middle of a frame. A design without frame-start capture would alter the remaining lines.
- Reset asserted mid-run, followed by a one-cycle pulse that checks the latency is exactly one clock.

// File: rtl/sync_cfg_pkg.sv
package sync_cfg_pkg;
  localparam int DLY_W = 8;

  typedef struct packed {
    logic             vs_inv;
    logic             hs_inv;
    logic             csync_sel;
    logic             no_eq;
    logic [DLY_W-1:0] vdelay;
  } out_mode_t;
endpackage

// File: rtl/so_vdelay.sv
// Vertical sync delay built from two edge counters instead of a long shift line.
module so_vdelay #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          vs_in,
  input  logic          vs_rise,
  input  logic          vs_fall,
  input  logic [DW-1:0] dly,
  output logic          vs_dly
);
  localparam logic [DW-1:0] D_ONE = DW'(1);

  logic [DW-1:0] rcnt_q, fcnt_q;
  logic          rbusy_q, fbusy_q, lev_q;
  logic          r_fire, f_fire;

  // Fire in the cycle before the delayed edge must be visible.
  assign r_fire = (vs_rise && dly == D_ONE) || (rbusy_q && rcnt_q == D_ONE);
  assign f_fire = (vs_fall && dly == D_ONE) || (fbusy_q && fcnt_q == D_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      rcnt_q  <= '0;
      fcnt_q  <= '0;
      rbusy_q <= 1'b0;
      fbusy_q <= 1'b0;
      lev_q   <= 1'b0;
    end else begin
      if (vs_rise && dly > D_ONE) begin
        rbusy_q <= 1'b1;
        rcnt_q  <= dly - D_ONE;
      end else if (rbusy_q) begin
        if (rcnt_q == D_ONE) rbusy_q <= 1'b0;
        else                 rcnt_q  <= rcnt_q - D_ONE;
      end

      if (vs_fall && dly > D_ONE) begin
        fbusy_q <= 1'b1;
        fcnt_q  <= dly - D_ONE;
      end else if (fbusy_q) begin
        if (fcnt_q == D_ONE) fbusy_q <= 1'b0;
        else                 fcnt_q  <= fcnt_q - D_ONE;
      end

      if (f_fire)      lev_q <= 1'b0;
      else if (r_fire) lev_q <= 1'b1;
    end
  end

  assign vs_dly = (dly == '0) ? vs_in : lev_q;
endmodule

// File: rtl/so_csync.sv
// Composite sync former: serration, equalization window tracking, half-line pulses.
module so_csync #(
  parameter int PIX_W    = 12,
  parameter int LINE_W   = 11,
  parameter int EQ_LINES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             hs_rise,
  input  logic             vs_rise,
  input  logic             vs_fall,
  input  logic             no_eq,
  input  logic [PIX_W-1:0] half_line,
  input  logic [PIX_W-1:0] hs_width,
  output logic             csync
);
  localparam logic [LINE_W-1:0] L_ONE = LINE_W'(1);
  localparam logic [LINE_W-1:0] L_EQ  = LINE_W'(EQ_LINES);
  localparam logic [LINE_W:0]   X_EQ  = (LINE_W + 1)'(EQ_LINES);
  localparam logic [PIX_W-1:0]  P_MAX = '1;

  logic [PIX_W-1:0]  pcnt_q, pos, eq_w;
  logic [LINE_W-1:0] ln_q, ln, vend_q, vend_now, flen_q;
  logic              post_ok_q, seen_q, flen_ok_q;
  logic              post_eq, pre_eq, eq_pulse;

  always_comb begin
    if (hs_rise)              pos = '0;
    else if (pcnt_q == P_MAX) pos = pcnt_q;
    else                      pos = pcnt_q + 1'b1;

    if (vs_rise)      ln = '0;
    else if (hs_rise) ln = ln_q + L_ONE;
    else              ln = ln_q;
  end

  assign vend_now = vs_fall ? ln : vend_q;
  assign post_eq  = !vs_in && (vs_fall || post_ok_q) && ((ln - vend_now) < L_EQ);
  assign pre_eq   = flen_ok_q && !vs_in && (({1'b0, ln} + X_EQ) >= {1'b0, flen_q});
  assign eq_w     = hs_width >> 1;
  assign eq_pulse = (pos < eq_w) || ((pos >= half_line) && ((pos - half_line) < eq_w));

  always_comb begin
    if (vs_in)                          csync = ~hs_in;
    else if ((pre_eq || post_eq) && !no_eq) csync = eq_pulse;
    else                                csync = hs_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q    <= '0;
      ln_q      <= '0;
      vend_q    <= '0;
      flen_q    <= '0;
      post_ok_q <= 1'b0;
      seen_q    <= 1'b0;
      flen_ok_q <= 1'b0;
    end else begin
      pcnt_q <= pos;
      ln_q   <= ln;
      if (vs_rise) begin
        post_ok_q <= 1'b0;
        flen_q    <= ln_q + L_ONE;
        seen_q    <= 1'b1;
        flen_ok_q <= seen_q;
      end else if (vs_fall) begin
        post_ok_q <= 1'b1;
        vend_q    <= ln;
      end
    end
  end
endmodule

// File: rtl/sync_out_cond.sv
module sync_out_cond
  import sync_cfg_pkg::*;
#(
  parameter int PIX_W    = 12,
  parameter int LINE_W   = 11,
  parameter int EQ_LINES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_in,
  input  logic             vs_in,
  input  logic             cfg_vs_inv,
  input  logic             cfg_hs_inv,
  input  logic             cfg_csync_sel,
  input  logic             cfg_no_eq,
  input  logic [DLY_W-1:0] cfg_vdelay,
  input  logic [PIX_W-1:0] cfg_half_line,
  input  logic [PIX_W-1:0] cfg_hs_width,
  output logic             hs_out,
  output logic             vs_out
);
  logic       vs_prev_q, hs_prev_q;
  logic       vs_rise, vs_fall, hs_rise;
  out_mode_t  cfg_now, shadow_q, eff;
  logic [PIX_W-1:0] half_q, hsw_q, half_eff, hsw_eff;
  logic       vs_dly, csync, hs_sel;

  assign vs_rise = vs_in & ~vs_prev_q;
  assign vs_fall = ~vs_in & vs_prev_q;
  assign hs_rise = hs_in & ~hs_prev_q;

  always_comb begin
    cfg_now.vs_inv    = cfg_vs_inv;
    cfg_now.hs_inv    = cfg_hs_inv;
    cfg_now.csync_sel = cfg_csync_sel;
    cfg_now.no_eq     = cfg_no_eq;
    cfg_now.vdelay    = cfg_csync_sel ? '0 : cfg_vdelay;
  end

  // Frame-start capture; the capture cycle itself already runs on the new values.
  assign eff      = vs_rise ? cfg_now       : shadow_q;
  assign half_eff = vs_rise ? cfg_half_line : half_q;
  assign hsw_eff  = vs_rise ? cfg_hs_width  : hsw_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vs_prev_q <= 1'b0;
      hs_prev_q <= 1'b0;
      shadow_q  <= '0;
      half_q    <= '0;
      hsw_q     <= '0;
    end else begin
      vs_prev_q <= vs_in;
      hs_prev_q <= hs_in;
      if (vs_rise) begin
        shadow_q <= cfg_now;
        half_q   <= cfg_half_line;
        hsw_q    <= cfg_hs_width;
      end
    end
  end

  so_vdelay #(.DW(DLY_W)) u_vdly (
    .clk     (clk),
    .rst     (rst),
    .vs_in   (vs_in),
    .vs_rise (vs_rise),
    .vs_fall (vs_fall),
    .dly     (eff.vdelay),
    .vs_dly  (vs_dly)
  );

  so_csync #(.PIX_W(PIX_W), .LINE_W(LINE_W), .EQ_LINES(EQ_LINES)) u_cs (
    .clk       (clk),
    .rst       (rst),
    .hs_in     (hs_in),
    .vs_in     (vs_in),
    .hs_rise   (hs_rise),
    .vs_rise   (vs_rise),
    .vs_fall   (vs_fall),
    .no_eq     (eff.no_eq),
    .half_line (half_eff),
    .hs_width  (hsw_eff),
    .csync     (csync)
  );

  assign hs_sel = eff.csync_sel ? csync : hs_in;

  // Polarity is the final stage ahead of the output flops.
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_out <= 1'b0;
      vs_out <= 1'b0;
    end else begin
      hs_out <= hs_sel ^ eff.hs_inv;
      vs_out <= vs_dly ^ eff.vs_inv;
    end
  end
endmodule

// File: rtl/sync_out_cond_chk.sv
module sync_out_cond_chk (
  input logic                    clk,
  input logic                    rst,
  input logic                    hs_in,
  input logic                    vs_in,
  input logic                    vs_rise,
  input sync_cfg_pkg::out_mode_t eff,
  input sync_cfg_pkg::out_mode_t shadow_q,
  input logic                    hs_out,
  input logic                    vs_out
);
  AST_HS_PLAIN_PATH: assert property (@(posedge clk) disable iff (rst)
    !eff.csync_sel |=> hs_out == ($past(hs_in) ^ $past(eff.hs_inv))); // R2

  AST_CSYNC_NO_VDELAY: assert property (@(posedge clk) disable iff (rst)
    eff.csync_sel |=> vs_out == ($past(vs_in) ^ $past(eff.vs_inv))); // R4

  AST_SERRATION_INVERT: assert property (@(posedge clk) disable iff (rst)
    (eff.csync_sel && vs_in) |=> hs_out == (~$past(hs_in) ^ $past(eff.hs_inv))); // R7

  AST_NO_EQ_PULSES: assert property (@(posedge clk) disable iff (rst)
    (eff.csync_sel && eff.no_eq && !vs_in) |=> hs_out == ($past(hs_in) ^ $past(eff.hs_inv))); // R5

  AST_MODE_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !vs_rise |=> $stable(shadow_q)); // R8
endmodule

bind sync_out_cond sync_out_cond_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .hs_in    (hs_in),
  .vs_in    (vs_in),
  .vs_rise  (vs_rise),
  .eff      (eff),
  .shadow_q (shadow_q),
  .hs_out   (hs_out),
  .vs_out   (vs_out)
);

// File: tb/sim_sync_out_cond.sv
`timescale 1ns/1ps
module sim_sync_out_cond;
  localparam int LINE = 300;
  localparam int HSW  = 20;
  localparam int FL   = 12;
  localparam int VW   = 3;
  localparam int EQ   = 3;
  localparam int NENT = 8;
  // entry bits: [13] vs_inv [12] hs_inv [11] csync_sel [10] no_eq [9:2] vdelay [1:0] frames
  localparam logic [13:0] TBL [NENT] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd0,   2'd2},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd1,   2'd1},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd2,   2'd1},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'h80,  2'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd255, 2'd1},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd200, 2'd2},
    {1'b1, 1'b1, 1'b1, 1'b1, 8'd50,  2'd2},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   2'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hs_in = 1'b0, vs_in = 1'b0;
  logic        cfg_vs_inv, cfg_hs_inv, cfg_csync_sel, cfg_no_eq;
  logic [7:0]  cfg_vdelay;
  logic [11:0] cfg_half_line = 12'(LINE / 2);
  logic [11:0] cfg_hs_width  = 12'(HSW);
  logic        hs_out, vs_out;

  int checks = 0;
  int fails  = 0;
  int frame_idx = 0;
  int cyc = 0;
  bit hist [512];
  logic f_vinv, f_hinv, f_csel, f_noeq;
  int   f_d;

  always #4 clk = ~clk;

  sync_out_cond u0 (
    .clk(clk), .rst(rst), .hs_in(hs_in), .vs_in(vs_in),
    .cfg_vs_inv(cfg_vs_inv), .cfg_hs_inv(cfg_hs_inv),
    .cfg_csync_sel(cfg_csync_sel), .cfg_no_eq(cfg_no_eq),
    .cfg_vdelay(cfg_vdelay), .cfg_half_line(cfg_half_line),
    .cfg_hs_width(cfg_hs_width), .hs_out(hs_out), .vs_out(vs_out)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t act=%0b exp=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic apply_cfg(input logic [13:0] e);
    cfg_vs_inv    = e[13];
    cfg_hs_inv    = e[12];
    cfg_csync_sel = e[11];
    cfg_no_eq     = e[10];
    cfg_vdelay    = e[9:2];
  endtask

  task automatic run_frame(input bit change, input logic [13:0] nxt);
    for (int l = 0; l < FL; l++) begin
      for (int p = 0; p < LINE; p++) begin
        logic hsv, vsv, cs, pulse, ehs, evs, pend;
        int   d;
        bit   pre, post;
        string ths, tvs;
        @(negedge clk);
        hsv = (p < HSW);
        vsv = (l < VW);
        hs_in = hsv;
        vs_in = vsv;
        if (l == 0 && p == 0) begin
          f_vinv = cfg_vs_inv; f_hinv = cfg_hs_inv;
          f_csel = cfg_csync_sel; f_noeq = cfg_no_eq; f_d = int'(cfg_vdelay);
        end
        pend = ({cfg_vs_inv, cfg_hs_inv, cfg_csync_sel, cfg_no_eq, cfg_vdelay} !==
                {f_vinv, f_hinv, f_csel, f_noeq, 8'(f_d)});
        hist[cyc % 512] = vsv;
        d = f_csel ? 0 : f_d;
        evs = (cyc >= d) ? hist[(cyc - d) % 512] : 1'b0;
        cyc++;
        post  = (l >= VW) && (l < VW + EQ);
        pre   = (frame_idx >= 1) && (l >= FL - EQ);
        pulse = (p < HSW / 2) || (p >= LINE / 2 && p < LINE / 2 + HSW / 2);
        if (vsv)                      cs = !hsv;
        else if ((pre || post) && !f_noeq) cs = pulse;
        else                          cs = hsv;
        ehs = (f_csel ? cs : hsv) ^ f_hinv;
        evs = evs ^ f_vinv;
        if (pend)                         ths = "R8 mid-frame change held off hs";
        else if (!f_csel)                 ths = f_hinv ? "R1 hs invert" : "R2 plain hs";
        else if (vsv)                     ths = "R7 serration";
        else if ((pre || post) && f_noeq) ths = "R5 no equalization";
        else if (pre || post)             ths = "R6 equalization pulse";
        else                              ths = "R2 composite hs";
        if (pend)                 tvs = "R8 mid-frame change held off vs";
        else if (f_csel && f_d != 0) tvs = "R4 delay forced to 0";
        else if (f_d != 0)        tvs = "R3 vs delay";
        else if (f_vinv)          tvs = "R1 vs invert";
        else                      tvs = "R9 vs latency";
        if (change && l == 6 && p == 37) apply_cfg(nxt);
        @(posedge clk);
        #2;
        check_bit(ths, hs_out, ehs);
        check_bit(tvs, vs_out, evs);
      end
    end
    frame_idx++;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R9 watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) hist[i] = 1'b0;
    apply_cfg(TBL[0]);
    repeat (4) @(negedge clk);
    check_bit("R10 reset hs_out low", hs_out, 1'b0);
    check_bit("R10 reset vs_out low", vs_out, 1'b0);
    rst = 1'b0;

    for (int i = 0; i < NENT; i++) begin
      int nfr, ni;
      nfr = int'(TBL[i][1:0]);
      ni  = (i < NENT - 1) ? i + 1 : i;
      for (int f = 0; f < nfr; f++)
        run_frame((f == nfr - 1) && (i < NENT - 1), TBL[ni]);
    end

    // R10: reset mid-run with active inputs drives both outputs low
    @(negedge clk);
    rst = 1'b1; hs_in = 1'b1; vs_in = 1'b1;
    @(posedge clk); #2;
    check_bit("R10 mid-run reset hs_out", hs_out, 1'b0);
    check_bit("R10 mid-run reset vs_out", vs_out, 1'b0);
    @(negedge clk);
    hs_in = 1'b0; vs_in = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: single-cycle pulse appears exactly one clock later; R10: plain mode after reset
    hs_in = 1'b1;
    #1;
    check_bit("R9 no combinational path", hs_out, 1'b0);
    @(posedge clk); #2;
    check_bit("R9 one-clock latency rise", hs_out, 1'b1);
    @(negedge clk);
    hs_in = 1'b0;
    @(posedge clk); #2;
    check_bit("R9 one-clock latency fall", hs_out, 1'b0);
    check_bit("R10 vs_out idle after reset", vs_out, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule